// File: doc/BRIEF.md
# I2C Interrupt and DMA Request Router

This block sits between an I2C controller's protocol engine and the rest of the chip. The engine raises one internal interrupt condition. This block sends that condition to up to three places: a CPU interrupt line, a transmit DMA request and a receive DMA request. An interrupt control register holds one enable bit per destination. When the condition is pending, each enabled destination sees it. The choice between the two DMA requests depends on the transfer direction that was in force when the event happened.

The block also offers an optional interrupt when the bus turns idle. A STOP condition normally raises no interrupt. When the idle enable bit is set, a busy-to-idle transition sets a sticky flag that drives the CPU interrupt line. The flag is cleared when software clears the idle enable bit or when the bus becomes busy again.

Software reaches the control register through a plain write strobe and a byte-wide read-back bus. The reset input is asserted asynchronously. It is released on a clock edge by a synchronizer inside the block, so the register comes out of reset two clock edges after `rst_n` rises.

Top module: `i2c_irq_router`

## Requirements
- R1: `cpu_irq` is high when an event is pending and the CPU enable (control bit 0) is 1. A pending event never raises `cpu_irq` while that bit is 0.
- R2: `dma_tx_req` is high only when an event is pending, the transmit-DMA enable (control bit 1) is 1, and the latched direction is transmit (`xfer_is_tx`=1).
- R3: `dma_rx_req` is high only when an event is pending, the receive-DMA enable (control bit 2) is 1, and the latched direction is receive (`xfer_is_tx`=0).
- R4: Several destinations may fire at once. `cpu_irq` and one DMA request can be high together. `dma_tx_req` and `dma_rx_req` are never high together.
- R5: After reset the control register reads 8'h01: CPU enable set, all other enables clear.
- R6: The direction is captured on the clock edge at which `xfer_evt` is sampled high. Later changes of `xfer_is_tx` do not move an active DMA request to the other line.
- R7: The clock edge that samples `xfer_evt`=1 makes the event pending, and `cpu_irq` and the DMA request appear after that edge. `xfer_ack` clears the pending event on the following edge. If both inputs are high on the same edge, the event wins.
- R8: With the idle enable (control bit 3) set, the first clock edge that samples `bus_busy`=0 after a sample of 1 sets the idle flag, and `cpu_irq` goes high after that edge. The idle flag drives `cpu_irq` whatever the CPU enable bit holds.
- R9: With the idle enable clear, a busy-to-idle transition leaves `cpu_irq` low.
- R10: The idle flag stays set until a register write clears the idle enable, or until `bus_busy` is sampled high again. Either way it is low after that edge.
- R11: The control register is written with `reg_wr` high, and the write takes effect at that edge. Bits 7..4 of `reg_rdata` always read 0, whatever is written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read-back |
| xfer_evt | input | 1 | One-cycle transfer event pulse from the protocol engine |
| xfer_ack | input | 1 | Clears the pending transfer event |
| xfer_is_tx | input | 1 | Current direction: 1 transmit, 0 receive |
| bus_busy | input | 1 | Bus busy level from the protocol engine |
| cpu_irq | output | 1 | CPU interrupt line |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |

## Verification
The assertions assume three things about the inputs: `bus_busy` is a clean level, `xfer_evt` is a single-cycle pulse, and all inputs change away from the rising clock edge. The bench drives every input on the falling edge and samples on the next falling edge. It pulses the event and acknowledge strobes for exactly one cycle, and it moves `bus_busy` only as whole-cycle steps. Most of the register sweep runs with the bus held busy, so no idle interrupt mixes into the routing checks. The idle behaviour is then checked on its own, with the transfer-event path quiet.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned CTRL_W  = 4;
  localparam int unsigned BIT_CPU = 0;
  localparam int unsigned BIT_TXD = 1;
  localparam int unsigned BIT_RXD = 2;
  localparam int unsigned BIT_IDL = 3;
  localparam logic [CTRL_W-1:0] CTRL_RST = 4'b0001;

  typedef struct packed {
    logic idle_en;
    logic rxd_en;
    logic txd_en;
    logic cpu_en;
  } ctrl_t;
endpackage

// File: rtl/i2c_irq_rst_sync.sv
module i2c_irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_irq_ctrl_reg.sv
module i2c_irq_ctrl_reg
  import i2c_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output ctrl_t            ctrl_q,
  output ctrl_t            ctrl_d,
  output logic [REG_W-1:0] rdata
);
  logic unused_hi;

  assign unused_hi = ^wdata[REG_W-1:CTRL_W];

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr) ctrl_d = ctrl_t'(wdata[CTRL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctrl_q <= ctrl_t'(CTRL_RST);
    else if (wr) ctrl_q <= ctrl_d;
  end

  assign rdata = {{(REG_W-CTRL_W){1'b0}}, ctrl_q};
endmodule

// File: rtl/i2c_irq_evt_track.sv
module i2c_irq_evt_track (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic ack,
  input  logic is_tx,
  output logic pend_q,
  output logic dir_tx_q
);
  logic pend_d;
  logic dir_d;
  logic pend_en;

  always_comb begin
    pend_en = evt | ack;
    pend_d  = evt;
    dir_d   = is_tx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   dir_tx_q <= 1'b0;
    else if (evt) dir_tx_q <= dir_d;
  end
endmodule

// File: rtl/i2c_irq_idle_det.sv
module i2c_irq_idle_det (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_busy,
  input  logic idle_en_d,
  output logic idle_flag_q
);
  logic busy_q;
  logic busy_fall;
  logic busy_rise;
  logic idle_d;

  always_comb begin
    busy_fall = busy_q & ~bus_busy;
    busy_rise = ~busy_q & bus_busy;
    idle_d    = idle_en_d & ~busy_rise & (idle_flag_q | busy_fall);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      idle_flag_q <= 1'b0;
    end else begin
      busy_q      <= bus_busy;
      idle_flag_q <= idle_d;
    end
  end
endmodule

// File: rtl/i2c_irq_router.sv
module i2c_irq_router
  import i2c_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             xfer_evt,
  input  logic             xfer_ack,
  input  logic             xfer_is_tx,
  input  logic             bus_busy,
  output logic             cpu_irq,
  output logic             dma_tx_req,
  output logic             dma_rx_req
);
  logic  rst_n_i;
  ctrl_t ctrl_q;
  ctrl_t ctrl_d;
  logic  pend_q;
  logic  dir_tx_q;
  logic  idle_flag_q;

  i2c_irq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  i2c_irq_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n_i), .wr(reg_wr), .wdata(reg_wdata),
    .ctrl_q(ctrl_q), .ctrl_d(ctrl_d), .rdata(reg_rdata)
  );

  i2c_irq_evt_track u_evt (
    .clk(clk), .rst_n(rst_n_i), .evt(xfer_evt), .ack(xfer_ack),
    .is_tx(xfer_is_tx), .pend_q(pend_q), .dir_tx_q(dir_tx_q)
  );

  i2c_irq_idle_det u_idle (
    .clk(clk), .rst_n(rst_n_i), .bus_busy(bus_busy),
    .idle_en_d(ctrl_d.idle_en), .idle_flag_q(idle_flag_q)
  );

  always_comb begin
    cpu_irq    = (pend_q & ctrl_q.cpu_en) | idle_flag_q;
    dma_tx_req = pend_q & ctrl_q.txd_en & dir_tx_q;
    dma_rx_req = pend_q & ctrl_q.rxd_en & ~dir_tx_q;
  end
endmodule

// File: rtl/i2c_irq_router_chk.sv
module i2c_irq_router_chk (
  input logic       clk,
  input logic       rst_n_i,
  input logic [7:0] reg_rdata,
  input logic       bus_busy,
  input logic       cpu_irq,
  input logic       dma_tx_req,
  input logic       dma_rx_req,
  input logic       pend_q,
  input logic       idle_flag_q
);
  p_cpu_src_r1: assert property (@(posedge clk) disable iff (!rst_n_i)
    cpu_irq |-> ((pend_q && reg_rdata[0]) || idle_flag_q));

  p_tx_en_r2: assert property (@(posedge clk) disable iff (!rst_n_i)
    dma_tx_req |-> (reg_rdata[1] && pend_q));

  p_rx_en_r3: assert property (@(posedge clk) disable iff (!rst_n_i)
    dma_rx_req |-> (reg_rdata[2] && pend_q));

  p_dma_excl_r4: assert property (@(posedge clk) disable iff (!rst_n_i)
    !(dma_tx_req && dma_rx_req));

  p_rst_val_r5: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(rst_n_i) |-> (reg_rdata == 8'h01));

  p_idle_src_r8: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(idle_flag_q) |-> !$past(bus_busy));

  p_idle_en_r10: assert property (@(posedge clk) disable iff (!rst_n_i)
    idle_flag_q |-> reg_rdata[3]);

  p_hi_zero_r11: assert property (@(posedge clk) disable iff (!rst_n_i)
    reg_rdata[7:4] == 4'h0);
endmodule

bind i2c_irq_router i2c_irq_router_chk u_chk (
  .clk(clk), .rst_n_i(rst_n_i), .reg_rdata(reg_rdata), .bus_busy(bus_busy),
  .cpu_irq(cpu_irq), .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req),
  .pend_q(pend_q), .idle_flag_q(idle_flag_q)
);

// File: tb/i2c_irq_router_bench.sv
module i2c_irq_router_bench;
  logic       clk;
  logic       rst_n;
  logic       reg_wr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       xfer_evt;
  logic       xfer_ack;
  logic       xfer_is_tx;
  logic       bus_busy;
  logic       cpu_irq;
  logic       dma_tx_req;
  logic       dma_rx_req;
  int         n_chk;
  int         n_err;
  logic       done;

  i2c_irq_router u_i2c_irq_router (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .xfer_evt(xfer_evt), .xfer_ack(xfer_ack),
    .xfer_is_tx(xfer_is_tx), .bus_busy(bus_busy), .cpu_irq(cpu_irq),
    .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] outs();
    return {5'b0, cpu_irq, dma_tx_req, dma_rx_req};
  endfunction

  task automatic wr(input logic [7:0] v);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic pulse_evt(input logic d, input logic with_ack);
    @(negedge clk); xfer_evt = 1'b1; xfer_ack = with_ack; xfer_is_tx = d;
    @(negedge clk); xfer_evt = 1'b0; xfer_ack = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); xfer_ack = 1'b1;
    @(negedge clk); xfer_ack = 1'b0;
  endtask

  task automatic set_busy(input logic b);
    @(negedge clk); bus_busy = b;
    @(negedge clk);
  endtask

  initial begin
    n_chk = 0; n_err = 0; done = 1'b0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    xfer_evt = 1'b0; xfer_ack = 1'b0; xfer_is_tx = 1'b0; bus_busy = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R5 reset value", reg_rdata, 8'h01);
    check("R5 reset outputs", outs(), 8'h00);

    // R1 R2 R3 R4 R6 R7 R11: sweep all enables and both directions
    for (int cfg = 0; cfg < 16; cfg++) begin
      for (int d = 0; d < 2; d++) begin
        logic ie, te, re;
        logic [7:0] e;
        wr(8'hF0 | 8'(cfg));
        check("R11 readback", reg_rdata, 8'(cfg));
        ie = cfg[0]; te = cfg[1]; re = cfg[2];
        pulse_evt(d[0], 1'b0);
        e = {5'b0, ie, te & d[0], re & ~d[0]};
        check("R1 R2 R3 R4 routing", outs(), e);
        @(negedge clk); xfer_is_tx = ~d[0];
        @(negedge clk);
        check("R6 dir latched", outs(), e);
        pulse_ack();
        check("R7 ack clears", outs(), 8'h00);
      end
    end

    // R7: event and ack on the same edge -> pending
    wr(8'h07);
    pulse_evt(1'b1, 1'b1);
    check("R7 evt beats ack", outs(), 8'h06);
    pulse_ack();
    check("R7 cleared", outs(), 8'h00);

    // R9: idle disabled, STOP gives nothing
    wr(8'h00);
    set_busy(1'b0);
    check("R9 no idle irq", outs(), 8'h00);
    set_busy(1'b1);

    // R8, R10: idle irq, cleared by disabling
    wr(8'h08);
    set_busy(1'b0);
    check("R8 idle irq set", outs(), 8'h04);
    repeat (3) @(negedge clk);
    check("R10 idle irq held", outs(), 8'h04);
    wr(8'h00);
    check("R10 cleared by enable", outs(), 8'h00);

    // R10: cleared by new transaction
    wr(8'h08);
    check("R10 no fresh fall", outs(), 8'h00);
    set_busy(1'b1);
    set_busy(1'b0);
    check("R8 idle irq again", outs(), 8'h04);
    set_busy(1'b1);
    check("R10 cleared by busy", outs(), 8'h00);
    check("R10 enable kept", reg_rdata, 8'h08);
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got %h expected %h", 1'b0, 1'b1);
    end
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule